// File: doc/BRIEF.md
# Vector Element Predicate Sequencer

This block walks a vector loop of up to 64 elements and issues one predicate bit per element, one element per clock. A one-cycle start pulse captures the loop length and the configuration. The block then steps an element counter from zero upward, and for each element it presents a valid strobe, the element index and the predicate bit. The done flag rises together with the last element.

The predicate can come from either of two sources. The first is a 64-bit integer source, where element i takes arithmetic bit i, so element 0 takes the least significant bit. The second is a vector of 64 four-bit condition fields, where a two-bit flag select picks one bit inside each field. For the condition source, an ordering select chooses how elements map to fields. In natural order, element i uses field i. In legacy order, the field numbers run backwards inside each aligned group of eight fields. The two source inputs are sampled live while the loop runs, and the caller holds them stable. Executing the elements and writing back results belong to other blocks.

Top module: `elem_pred_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, `elem_valid_o` and `done_o` are 0 until a start is accepted.
- R2: A start accepted at a clock edge with loop length L ≥ 1 makes `elem_valid_o` high from the next cycle for exactly L consecutive cycles. During those cycles `elem_idx_o` takes the values 0, 1, …, L−1, one per cycle.
- R3: `done_o` is high in the cycle that issues element L−1 and in no other cycle of the loop. `elem_valid_o` is low in the cycle that follows.
- R4: A start with loop length 0 raises `done_o` for exactly one cycle in the next cycle and never raises `elem_valid_o`.
- R5: A start pulse that arrives while a loop is running, or during the single done cycle of a zero-length start, is ignored. The running loop continues unchanged, and no second loop follows.
- R6: With `pred_mode_i` = 0 (integer source), the predicate for element i is `int_src_i[i]`, the arithmetic bit i. This is MSB0-numbered bit 63−i.
- R7: With `pred_mode_i` = 1 (condition source) and `legacy_order_i` = 0, element i uses field i, which is `cr_src_i[4i+3:4i]`.
- R8: Within the selected field, flag select value 0 picks bit 4n+3, the most significant bit, and value 3 picks bit 4n, the least significant bit. In general value s picks bit 4n+3−s.
- R9: With `legacy_order_i` = 1, element i uses field n = (i with its low three bits cleared) OR (7 − (i mod 8)). This gives the field sequence 7…0, 15…8, 23…16, and so on.
- R10: Mode, flag select, ordering and loop length are captured at the accepted start. Changes on those inputs during a running loop have no effect on the loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| vl_i | input | 7 | Loop length, 0 to 64 |
| pred_mode_i | input | 1 | 0 selects the integer source, 1 selects the condition-field source |
| flag_sel_i | input | 2 | Selects the flag bit within a condition field |
| legacy_order_i | input | 1 | 1 selects the group-of-eight reversed field order |
| int_src_i | input | 64 | Integer predicate source, arithmetic bit numbering |
| cr_src_i | input | 256 | 64 condition fields, field n at bits 4n+3:4n |
| elem_valid_o | output | 1 | An element is issued this cycle |
| elem_idx_o | output | 6 | Index of the issued element |
| pred_o | output | 1 | Predicate bit of the issued element, 0 when no element is issued |
| done_o | output | 1 | Loop finishes this cycle |

## Verification
A counter that skips or repeats a value shows up at the ports in the same cycle as an index out of sequence. It also shifts every later predicate bit, so a check against a source pattern with no regular structure exposes it at once. A wrong last-element compare either moves `done_o` away from index L−1 or leaves `elem_valid_o` high one cycle too long. Both are visible within one cycle of the end of the loop. Stale or overwritten captured configuration shows up as predicate mismatches from the first element issued after the disturbance. The bench therefore changes the configuration inputs and pulses start during a loop, and keeps comparing every element afterwards.

// File: rtl/pred_seq_pkg.sv
package pred_seq_pkg;
  localparam int FLAG_BITS = 4;
  localparam int FLAG_SEL_W = $clog2(FLAG_BITS);

  typedef enum logic {
    PM_INT = 1'b0,
    PM_CR  = 1'b1
  } pred_mode_e;

  typedef struct packed {
    pred_mode_e            mode;
    logic [FLAG_SEL_W-1:0] flag_sel;
    logic                  legacy;
  } seq_cfg_t;
endpackage

// File: rtl/pred_seq_ctrl.sv
module pred_seq_ctrl
  import pred_seq_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int VL_W  = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VL_W-1:0]  vl_i,
  input  seq_cfg_t         cfg_i,
  output logic             busy_o,
  output logic             last_o,
  output logic             zdone_o,
  output logic [IDX_W-1:0] cnt_o,
  output seq_cfg_t         cfg_o
);
  logic             busy_q, busy_d;
  logic             zdone_q, zdone_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic [VL_W-1:0]  vl_q;
  seq_cfg_t         cfg_q;
  logic             running, accept, last;

  assign running = busy_q | zdone_q;
  assign accept  = start_i & ~running;
  assign last    = busy_q && ((VL_W'(cnt_q) + VL_W'(1)) == vl_q);

  // next-state
  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    zdone_d = 1'b0;
    if (accept) begin
      cnt_d = '0;
      if (vl_i == '0) zdone_d = 1'b1;
      else            busy_d  = 1'b1;
    end else if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + IDX_W'(1);
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      zdone_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      zdone_q <= zdone_d;
      cnt_q   <= cnt_d;
    end
  end

  // configuration capture, enabled only by an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q  <= '0;
      cfg_q <= '0;
    end else if (accept) begin
      vl_q  <= vl_i;
      cfg_q <= cfg_i;
    end
  end

  assign busy_o  = busy_q;
  assign last_o  = last;
  assign zdone_o = zdone_q;
  assign cnt_o   = cnt_q;
  assign cfg_o   = cfg_q;

  assert_idx_below_vl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (VL_W'(cnt_q) < vl_q));
  assert_idx_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> (busy_q && cnt_q == $past(cnt_q) + IDX_W'(1)));
  assert_done_ends_loop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy_q);
  assert_zero_vl_no_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    zdone_q |-> (!busy_q && vl_q == '0));
  assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last && start_i) |=> (busy_q && cnt_q == $past(cnt_q) + IDX_W'(1)));
  assert_cfg_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(cfg_q) && $stable(vl_q)));
endmodule

// File: rtl/pred_field_map.sv
module pred_field_map #(
  parameter int IDX_W = 6,
  parameter int GROUP_LOG2 = 3
) (
  input  logic             legacy_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] field_o
);
  logic [IDX_W-1:0] rev;

  generate
    if (IDX_W > GROUP_LOG2) begin : g_grouped
      assign rev = {idx_i[IDX_W-1:GROUP_LOG2], ~idx_i[GROUP_LOG2-1:0]};
    end else begin : g_single
      assign rev = ~idx_i;
    end
  endgenerate

  assign field_o = legacy_i ? rev : idx_i;
endmodule

// File: rtl/pred_bit_select.sv
module pred_bit_select
  import pred_seq_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input  pred_mode_e                  mode_i,
  input  logic [FLAG_SEL_W-1:0]       flag_sel_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [IDX_W-1:0]            field_i,
  input  logic [MAX_VL-1:0]           int_src_i,
  input  logic [MAX_VL*FLAG_BITS-1:0] cr_src_i,
  output logic                        pred_o
);
  logic [FLAG_BITS-1:0]  fields [MAX_VL];
  logic [FLAG_BITS-1:0]  sel_field;
  logic [FLAG_SEL_W-1:0] flag_pos;

  for (genvar g = 0; g < MAX_VL; g++) begin : g_fields
    assign fields[g] = cr_src_i[g*FLAG_BITS +: FLAG_BITS];
  end

  always_comb begin
    sel_field = fields[field_i];
    flag_pos  = FLAG_SEL_W'(FLAG_BITS - 1) - flag_sel_i;
    pred_o    = (mode_i == PM_INT) ? int_src_i[idx_i] : sel_field[flag_pos];
  end
endmodule

// File: rtl/elem_pred_sequencer.sv
module elem_pred_sequencer
  import pred_seq_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int GROUP_LOG2 = 3,
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int VL_W  = IDX_W + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [VL_W-1:0]             vl_i,
  input  logic                        pred_mode_i,
  input  logic [FLAG_SEL_W-1:0]       flag_sel_i,
  input  logic                        legacy_order_i,
  input  logic [MAX_VL-1:0]           int_src_i,
  input  logic [MAX_VL*FLAG_BITS-1:0] cr_src_i,
  output logic                        elem_valid_o,
  output logic [IDX_W-1:0]            elem_idx_o,
  output logic                        pred_o,
  output logic                        done_o
);
  seq_cfg_t         cfg_in, cfg_q;
  logic             busy, last, zdone, pred_raw;
  logic [IDX_W-1:0] cnt, field;

  assign cfg_in.mode     = pred_mode_e'(pred_mode_i);
  assign cfg_in.flag_sel = flag_sel_i;
  assign cfg_in.legacy   = legacy_order_i;

  pred_seq_ctrl #(.MAX_VL(MAX_VL)) ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .vl_i   (vl_i),
    .cfg_i  (cfg_in),
    .busy_o (busy),
    .last_o (last),
    .zdone_o(zdone),
    .cnt_o  (cnt),
    .cfg_o  (cfg_q)
  );

  pred_field_map #(.IDX_W(IDX_W), .GROUP_LOG2(GROUP_LOG2)) map_i (
    .legacy_i(cfg_q.legacy),
    .idx_i   (cnt),
    .field_o (field)
  );

  pred_bit_select #(.MAX_VL(MAX_VL)) sel_i (
    .mode_i    (cfg_q.mode),
    .flag_sel_i(cfg_q.flag_sel),
    .idx_i     (cnt),
    .field_i   (field),
    .int_src_i (int_src_i),
    .cr_src_i  (cr_src_i),
    .pred_o    (pred_raw)
  );

  assign elem_valid_o = busy;
  assign elem_idx_o   = cnt;
  assign pred_o       = busy & pred_raw;
  assign done_o       = last | zdone;

  assert_int_pred_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_valid_o && cfg_q.mode == PM_INT) |-> (pred_o == int_src_i[elem_idx_o]));
  assert_no_pred_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !elem_valid_o |-> !pred_o);
endmodule

// File: tb/elem_pred_sequencer_tb_top.sv
`timescale 1ns/1ps
module elem_pred_sequencer_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [6:0]   vl_i;
  logic         pred_mode_i;
  logic [1:0]   flag_sel_i;
  logic         legacy_order_i;
  logic [63:0]  int_src_i;
  logic [255:0] cr_src_i;
  logic         elem_valid_o;
  logic [5:0]   elem_idx_o;
  logic         pred_o;
  logic         done_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  elem_pred_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
    .pred_mode_i(pred_mode_i), .flag_sel_i(flag_sel_i),
    .legacy_order_i(legacy_order_i), .int_src_i(int_src_i),
    .cr_src_i(cr_src_i), .elem_valid_o(elem_valid_o),
    .elem_idx_o(elem_idx_o), .pred_o(pred_o), .done_o(done_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_pred(input logic m, input logic [1:0] s,
                                    input logic lg, input int k);
    int f;
    f = lg ? ((k & ~7) | (7 - (k % 8))) : k;
    if (!m) return int_src_i[k];
    return cr_src_i[4*f + 3 - int'(s)];
  endfunction

  // disturb: 0 none, 1 change cfg inputs mid-run (R10), 2 start pulses mid-run (R5)
  task automatic run_seq(input logic m, input logic [1:0] s, input logic lg,
                         input int vl, input int disturb, input string req);
    @(negedge clk);
    pred_mode_i = m; flag_sel_i = s; legacy_order_i = lg; vl_i = 7'(vl);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (disturb == 1) begin
      pred_mode_i = ~m; flag_sel_i = s + 2'd1; legacy_order_i = ~lg; vl_i = 7'd2;
    end
    if (disturb == 2) begin
      start_i = 1'b1; vl_i = 7'd3; pred_mode_i = ~m;
    end
    if (vl == 0) begin
      chk(req, "zero-length done", {63'b0, done_o}, 64'd1);
      chk(req, "zero-length valid", {63'b0, elem_valid_o}, 64'd0);
      if (disturb == 2) begin
        @(negedge clk);
        start_i = 1'b0;
      end else begin
        @(negedge clk);
      end
      chk(req, "zero-length done drops", {63'b0, done_o}, 64'd0);
      chk(req, "zero-length no issue", {63'b0, elem_valid_o}, 64'd0);
    end else begin
      for (int k = 0; k < vl; k++) begin
        if (k > 0) @(negedge clk);
        if (disturb == 2 && k == 2) start_i = 1'b0;
        chk(req, "valid", {63'b0, elem_valid_o}, 64'd1);
        chk(req, "index", {58'b0, elem_idx_o}, 64'(k));
        chk(req, "predicate", {63'b0, pred_o}, {63'b0, exp_pred(m, s, lg, k)});
        chk(req, "done", {63'b0, done_o}, {63'b0, (k == vl - 1)});
      end
      @(negedge clk);
      start_i = 1'b0;
      chk(req, "valid after loop", {63'b0, elem_valid_o}, 64'd0);
      chk(req, "done after loop", {63'b0, done_o}, 64'd0);
    end
    if (disturb == 2) begin
      @(negedge clk);
      chk(req, "no second loop", {63'b0, elem_valid_o}, 64'd0);
    end
    pred_mode_i = m; flag_sel_i = s; legacy_order_i = lg;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start_i = 1'b0; vl_i = '0; pred_mode_i = 1'b0;
    flag_sel_i = '0; legacy_order_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", {63'b0, elem_valid_o}, 64'd0);
    chk("R1", "done in reset", {63'b0, done_o}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "valid after reset", {63'b0, elem_valid_o}, 64'd0);
    chk("R1", "done after reset", {63'b0, done_o}, 64'd0);
  endtask

  task automatic t_int_mode;
    run_seq(1'b0, 2'd0, 1'b0, 64, 0, "R6");
    run_seq(1'b0, 2'd2, 1'b1, 13, 0, "R6");
  endtask

  task automatic t_cr_natural;
    for (int s = 0; s < 4; s++) run_seq(1'b1, 2'(s), 1'b0, 20, 0, "R7");
  endtask

  task automatic t_flag_select;
    run_seq(1'b1, 2'd0, 1'b0, 64, 0, "R8");
    run_seq(1'b1, 2'd3, 1'b0, 64, 0, "R8");
  endtask

  task automatic t_legacy;
    run_seq(1'b1, 2'd1, 1'b1, 64, 0, "R9");
    run_seq(1'b1, 2'd3, 1'b1, 11, 0, "R9");
  endtask

  task automatic t_lengths;
    run_seq(1'b1, 2'd0, 1'b0, 1, 0, "R2");
    run_seq(1'b0, 2'd0, 1'b0, 2, 0, "R3");
    run_seq(1'b0, 2'd0, 1'b0, 0, 0, "R4");
  endtask

  task automatic t_start_ignored;
    run_seq(1'b1, 2'd2, 1'b0, 10, 2, "R5");
    run_seq(1'b0, 2'd0, 1'b0, 0, 2, "R5");
  endtask

  task automatic t_cfg_change;
    run_seq(1'b1, 2'd1, 1'b1, 24, 1, "R10");
    run_seq(1'b0, 2'd0, 1'b0, 9, 1, "R10");
  endtask

  initial begin
    int_src_i = 64'hA5F0_3C96_0F1E_8B27;
    for (int f = 0; f < 64; f++) cr_src_i[4*f +: 4] = 4'((f * 7 + 3) % 16);
    t_reset();
    t_lengths();
    t_int_mode();
    t_cr_natural();
    t_flag_select();
    t_legacy();
    t_start_ignored();
    t_cfg_change();
    int_src_i = ~int_src_i;
    cr_src_i  = {cr_src_i[127:0], ~cr_src_i[255:128]};
    t_int_mode();
    t_legacy();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule